// File: doc/BRIEF.md
# Audio Link Frame Serializer

This block generates the frame timing of a time-division-multiplexed serial link toward external audio codecs. It runs from a system clock that is an even multiple (`DIV`) of the link bit clock and derives the bit clock, a frame sync, the codec reset and a serial data-out line from one phase counter and one bit counter. Each frame is `FB` bit clocks long. The sync line is high during the closing `SYNC_BITS` bit clocks of every frame. The data-out line carries two bits per bit clock, one in each half of the bit clock. With the default settings this gives a 24 MHz bit clock, a 48 kHz frame rate and 48 Mb/s on the output.

A command word is offered on a simple load port. It is transmitted most significant bit first in the frame that follows its acceptance, starting in the first bit clock after sync falls. Two serial input lanes carry one bit per bit clock. Each lane is sampled at the falling edge of the bit clock into its own shift register. At every frame boundary the captured words of both lanes are presented together, along with a one-cycle frame-done strobe.

After a system reset the codec reset output stays asserted for a set number of frames. The link then idles through a set number of settle frames with the bit clock and sync running. Only after that does it accept command words.

Top module: `audio_link_serializer`

## Requirements
- R1: `link_rst_n` is 0 while `rst` is high and for the first `RST_FRAMES` frames (`RST_FRAMES*FB*DIV` system clocks) after `rst` falls; after that it is 1.
- R2: While `link_rst_n` is 0, `link_clk`, `link_sync` and `link_sdo` are all 0. Otherwise `link_clk` is 1 for the first `DIV/2` system clocks of each `DIV`-clock bit period and 0 for the rest.
- R3: Bit clocks are numbered 0 to `FB-1` within a frame. Once the link is out of reset, `link_sync` is 1 exactly during bit clocks `FB-SYNC_BITS` to `FB-1`, and it falls as bit clock 0 of the next frame begins.
- R4: Output slot `s = 2*b + h` is bit clock `b`, with `h=0` for the first half and `h=1` for the second half. `link_sdo` carries bit `OUT_W-1-s` of the frame's command word for `s < OUT_W` and 0 for every higher slot. A frame with no command word sends all zeros.
- R5: `tx_ready` is 0 until `RST_FRAMES+SETTLE_FRAMES` frames after reset. A `tx_load` while `tx_ready` is 0 is ignored and changes nothing that is later sent.
- R6: One command word can be pending. A word accepted (`tx_load` with `tx_ready` high) in any frame, including its final cycle, is sent in the frame that begins at the next frame boundary. `tx_ready` is 0 while a word is pending.
- R7: Each lane `link_sdi[i]` is sampled in the system clock where the bit-clock phase is `DIV/2` (the bit clock's falling edge). Only bit clocks 0 to `IN_W-1` of a frame are sampled, and the first sampled bit ends up as the MSB of that lane's word.
- R8: `frame_done` is high for exactly one system clock, the first clock of each frame that follows a frame in which the link accepted commands. In that same clock `rx_lane0` and `rx_lane1` take the words captured in the finished frame; they hold their value at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, `DIV` times the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| link_rst_n | output | 1 | Active-low reset to the external codecs |
| link_clk | output | 1 | Link bit clock |
| link_sync | output | 1 | Frame sync, high at the end of each frame |
| link_sdo | output | 1 | Serial data out, two bits per bit clock |
| link_sdi | input | 2 | Serial data in, one bit per lane |
| tx_load | input | 1 | Offers `tx_word` for the next frame |
| tx_word | input | OUT_W | Command word, MSB sent first |
| tx_ready | output | 1 | A `tx_load` in this cycle is accepted |
| rx_lane0 | output | IN_W | Word captured from lane 0 |
| rx_lane1 | output | IN_W | Word captured from lane 1 |
| frame_done | output | 1 | One-cycle strobe with new captured words |

## Verification
`link_clk`, `link_sync`, `link_sdo`, `link_rst_n` and `tx_ready` are decoded from registered counters and state. They are therefore due in the same system clock as the counter value they describe. The bench computes the expected value of each one from its own count of system clocks since reset, sampled at the falling system-clock edge.

`frame_done` and the captured lane words appear one clock after the final cycle of a frame. A loaded word shows up only in the slots of the frame after its acceptance boundary, including a load made in the boundary cycle itself. The bench's model applies every posedge effect in that same order before it checks the next cycle.

Lane bits are changed at phase 0 and held for the whole bit period, so the phase-`DIV/2` sample is never ambiguous.

// File: rtl/audio_link_pkg.sv
package audio_link_pkg;

    // Link bring-up sequence
    typedef enum logic [1:0] {
        LNK_HOLD   = 2'd0,   // codec reset asserted
        LNK_SETTLE = 2'd1,   // clock and sync running, no commands
        LNK_RUN    = 2'd2    // commands accepted, lanes reported
    } link_state_e;

endpackage

// File: rtl/alink_timing.sv
module alink_timing #(
    parameter int DIV = 8,
    parameter int FB  = 500,
    localparam int PW = $clog2(DIV),
    localparam int BW = $clog2(FB)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] phase_o,
    output logic [BW-1:0] bidx_o,
    output logic          late_half_o,
    output logic          sample_o,
    output logic          frame_end_o
);
    localparam int HALF = DIV / 2;

    typedef struct packed {
        logic [PW-1:0] ph;
        logic [BW-1:0] bidx;
    } tim_t;

    tim_t tim_d, tim_q;

    always_comb begin
        tim_d = tim_q;
        if (tim_q.ph == PW'(DIV - 1)) begin
            tim_d.ph = '0;
            if (tim_q.bidx == BW'(FB - 1)) begin
                tim_d.bidx = '0;
            end else begin
                tim_d.bidx = tim_q.bidx + 1'b1;
            end
        end else begin
            tim_d.ph = tim_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tim_q <= '0;
        end else begin
            tim_q <= tim_d;
        end
    end

    assign phase_o     = tim_q.ph;
    assign bidx_o      = tim_q.bidx;
    assign late_half_o = (tim_q.ph >= PW'(HALF));
    assign sample_o    = (tim_q.ph == PW'(HALF));
    assign frame_end_o = (tim_q.ph == PW'(DIV - 1)) && (tim_q.bidx == BW'(FB - 1));

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        frame_end_o |=> (bidx_o == '0) && (phase_o == '0)); // R3

endmodule

// File: rtl/alink_tx.sv
module alink_tx #(
    parameter int FB    = 500,
    parameter int OUT_W = 40,
    localparam int BW   = $clog2(FB),
    localparam int SW   = BW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_end_i,
    input  logic             run_i,
    input  logic [BW-1:0]    bidx_i,
    input  logic             late_half_i,
    input  logic             load_i,
    input  logic [OUT_W-1:0] word_i,
    output logic             ready_o,
    output logic             sdo_o
);
    typedef struct packed {
        logic             pend_v;
        logic [OUT_W-1:0] pend;
        logic [OUT_W-1:0] cur;
    } tx_t;

    tx_t tx_d, tx_q;
    logic [SW-1:0] slot;

    assign ready_o = run_i && !tx_q.pend_v;
    assign slot    = {bidx_i, late_half_i};

    always_comb begin
        tx_d = tx_q;
        if (frame_end_i) begin
            tx_d.cur    = tx_q.pend_v ? tx_q.pend : '0;
            tx_d.pend_v = 1'b0;
        end
        if (load_i && ready_o) begin
            tx_d.pend_v = 1'b1;
            tx_d.pend   = word_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    // Slot s carries bit OUT_W-1-s of the current word
    always_comb begin
        sdo_o = 1'b0;
        for (int i = 0; i < OUT_W; i++) begin
            if (slot == SW'(OUT_W - 1 - i)) begin
                sdo_o = tx_q.cur[i];
            end
        end
    end

    AST_PENDING_HELD: assert property (@(posedge clk) disable iff (rst)
        (tx_q.pend_v && !frame_end_i) |=> (tx_q.pend_v && $stable(tx_q.pend))); // R6

endmodule

// File: rtl/alink_rx_lane.sv
module alink_rx_lane #(
    parameter int FB   = 500,
    parameter int IN_W = 36,
    localparam int BW  = $clog2(FB)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sample_i,
    input  logic            frame_end_i,
    input  logic            run_i,
    input  logic [BW-1:0]   bidx_i,
    input  logic            sdi_i,
    output logic [IN_W-1:0] word_o
);
    typedef struct packed {
        logic [IN_W-1:0] sh;
        logic [IN_W-1:0] word;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d = rx_q;
        if (sample_i && (bidx_i < BW'(IN_W))) begin
            rx_d.sh = {rx_q.sh[IN_W-2:0], sdi_i};
        end
        if (frame_end_i && run_i) begin
            rx_d.word = rx_q.sh;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign word_o = rx_q.word;

    AST_RX_STEADY: assert property (@(posedge clk) disable iff (rst)
        !(frame_end_i && run_i) |=> $stable(word_o)); // R8

endmodule

// File: rtl/audio_link_serializer.sv
module audio_link_serializer #(
    parameter int DIV           = 8,
    parameter int FB            = 500,
    parameter int SYNC_BITS     = 8,
    parameter int OUT_W         = 40,
    parameter int IN_W          = 36,
    parameter int RST_FRAMES    = 4,
    parameter int SETTLE_FRAMES = 2
) (
    input  logic             clk,
    input  logic             rst,
    output logic             link_rst_n,
    output logic             link_clk,
    output logic             link_sync,
    output logic             link_sdo,
    input  logic [1:0]       link_sdi,
    input  logic             tx_load,
    input  logic [OUT_W-1:0] tx_word,
    output logic             tx_ready,
    output logic [IN_W-1:0]  rx_lane0,
    output logic [IN_W-1:0]  rx_lane1,
    output logic             frame_done
);
    import audio_link_pkg::*;

    localparam int LANES  = 2;
    localparam int PW     = $clog2(DIV);
    localparam int BW     = $clog2(FB);
    localparam int MAXF   = (RST_FRAMES > SETTLE_FRAMES) ? RST_FRAMES : SETTLE_FRAMES;
    localparam int CW     = $clog2(MAXF + 1);

    typedef struct packed {
        link_state_e   st;
        logic [CW-1:0] fcnt;
        logic          done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [PW-1:0] phase;
    logic [BW-1:0] bidx;
    logic          late_half;
    logic          sample;
    logic          frame_end;
    logic          active;
    logic          run;
    logic          sdo_raw;
    logic [IN_W-1:0] rx_words [LANES];

    alink_timing #(.DIV(DIV), .FB(FB)) u_timing (
        .clk        (clk),
        .rst        (rst),
        .phase_o    (phase),
        .bidx_o     (bidx),
        .late_half_o(late_half),
        .sample_o   (sample),
        .frame_end_o(frame_end)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = frame_end && (ctl_q.st == LNK_RUN);
        if (frame_end) begin
            case (ctl_q.st)
                LNK_HOLD: begin
                    if (ctl_q.fcnt == CW'(RST_FRAMES - 1)) begin
                        ctl_d.st   = LNK_SETTLE;
                        ctl_d.fcnt = '0;
                    end else begin
                        ctl_d.fcnt = ctl_q.fcnt + 1'b1;
                    end
                end
                LNK_SETTLE: begin
                    if (ctl_q.fcnt == CW'(SETTLE_FRAMES - 1)) begin
                        ctl_d.st   = LNK_RUN;
                        ctl_d.fcnt = '0;
                    end else begin
                        ctl_d.fcnt = ctl_q.fcnt + 1'b1;
                    end
                end
                LNK_RUN: begin
                    ctl_d.fcnt = '0;
                end
                default: begin
                    ctl_d.st   = LNK_HOLD;
                    ctl_d.fcnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{st: LNK_HOLD, fcnt: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign active = (ctl_q.st != LNK_HOLD);
    assign run    = (ctl_q.st == LNK_RUN);

    alink_tx #(.FB(FB), .OUT_W(OUT_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .frame_end_i(frame_end),
        .run_i      (run),
        .bidx_i     (bidx),
        .late_half_i(late_half),
        .load_i     (tx_load),
        .word_i     (tx_word),
        .ready_o    (tx_ready),
        .sdo_o      (sdo_raw)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        alink_rx_lane #(.FB(FB), .IN_W(IN_W)) u_lane (
            .clk        (clk),
            .rst        (rst),
            .sample_i   (sample),
            .frame_end_i(frame_end),
            .run_i      (run),
            .bidx_i     (bidx),
            .sdi_i      (link_sdi[g]),
            .word_o     (rx_words[g])
        );
    end

    assign link_rst_n = active;
    assign link_clk   = active && !late_half;
    assign link_sync  = active && (bidx >= BW'(FB - SYNC_BITS));
    assign link_sdo   = active && sdo_raw;
    assign rx_lane0   = rx_words[0];
    assign rx_lane1   = rx_words[1];
    assign frame_done = ctl_q.done;

    AST_IDLE_WHILE_RESET: assert property (@(posedge clk) disable iff (rst)
        !link_rst_n |-> (!link_clk && !link_sync && !link_sdo)); // R2

    AST_READY_NEEDS_LINK: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> link_rst_n); // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done); // R8

    AST_SYNC_FALL_AT_START: assert property (@(posedge clk) disable iff (rst)
        $fell(link_sync) |-> (bidx == '0) && (phase == '0)); // R3

endmodule

// File: tb/audio_link_serializer_test.sv
module audio_link_serializer_test;
    localparam int DIV   = 4;
    localparam int FB    = 32;
    localparam int SYNC  = 4;
    localparam int OUT_W = 20;
    localparam int IN_W  = 16;
    localparam int RSTF  = 2;
    localparam int WAITF = 2;
    localparam int F     = DIV * FB;
    localparam int HALF  = DIV / 2;
    localparam int RUNF  = RSTF + WAITF;
    localparam int TOTAL = (RUNF + 8) * F;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic link_rst_n, link_clk, link_sync, link_sdo;
    logic [1:0] link_sdi = '0;
    logic tx_load = 1'b0;
    logic [OUT_W-1:0] tx_word = '0;
    logic tx_ready;
    logic [IN_W-1:0] rx_lane0, rx_lane1;
    logic frame_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    audio_link_serializer #(
        .DIV(DIV), .FB(FB), .SYNC_BITS(SYNC), .OUT_W(OUT_W), .IN_W(IN_W),
        .RST_FRAMES(RSTF), .SETTLE_FRAMES(WAITF)
    ) uut (
        .clk(clk), .rst(rst), .link_rst_n(link_rst_n), .link_clk(link_clk),
        .link_sync(link_sync), .link_sdo(link_sdo), .link_sdi(link_sdi),
        .tx_load(tx_load), .tx_word(tx_word), .tx_ready(tx_ready),
        .rx_lane0(rx_lane0), .rx_lane1(rx_lane1), .frame_done(frame_done)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic pat(input int l, input int fr, input int b);
        int v;
        v = fr * 13 + b * (l + 3) + (b >> 2) * (l + 1);
        return v[1] ^ v[3];
    endfunction

    // Model state mirroring the effect of each posedge
    logic             pend_v = 1'b0;
    logic [OUT_W-1:0] pend_w = '0;
    logic [OUT_W-1:0] cur_w  = '0;
    logic [IN_W-1:0]  sh0 = '0, sh1 = '0;
    logic [IN_W-1:0]  exp_rx0 = '0, exp_rx1 = '0;
    logic             exp_done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset link_rst_n", 64'(link_rst_n), 64'd0);
        chk("R2 reset link_clk", 64'(link_clk), 64'd0);
        chk("R2 reset link_sync", 64'(link_sync), 64'd0);
        chk("R5 reset tx_ready", 64'(tx_ready), 64'd0);
        chk("R8 reset frame_done", 64'(frame_done), 64'd0);
        rst = 1'b0;
        for (int j = 0; j < TOTAL; j++) begin
            int fr, ph, b, s, k;
            logic act, run, bnd, rdy, exp_sdo;
            fr  = j / F;
            ph  = j % DIV;
            b   = (j / DIV) % FB;
            act = (fr >= RSTF);
            run = (fr >= RUNF);
            s   = 2 * b + ((ph >= HALF) ? 1 : 0);
            exp_sdo = (act && s < OUT_W) ? cur_w[OUT_W-1-s] : 1'b0;

            chk("R1 link_rst_n", 64'(link_rst_n), 64'(act));
            chk("R2 link_clk", 64'(link_clk), 64'(act && ph < HALF));
            chk("R3 link_sync", 64'(link_sync), 64'(act && b >= FB - SYNC));
            chk("R4 link_sdo", 64'(link_sdo), 64'(exp_sdo));
            chk("R5 R6 tx_ready", 64'(tx_ready), 64'(run && !pend_v));
            chk("R8 frame_done", 64'(frame_done), 64'(exp_done));
            chk("R7 R8 rx_lane0", 64'(rx_lane0), 64'(exp_rx0));
            chk("R7 R8 rx_lane1", 64'(rx_lane1), 64'(exp_rx1));

            // Drive lanes: new bit launched at phase 0, held for the bit
            link_sdi = {pat(1, fr, b), pat(0, fr, b)};

            // Load stimulus
            tx_load = 1'b0;
            tx_word = '0;
            bnd = (ph == DIV - 1) && (b == FB - 1);
            if (fr == RSTF && b == 2 && ph == 1) begin
                tx_load = 1'b1;            // R5: ignored during settle
                tx_word = '1;
            end else if (run) begin
                k = fr - RUNF;
                if (k == 4) begin
                    if (bnd) begin         // R6: load in boundary cycle
                        tx_load = 1'b1;
                        tx_word = OUT_W'(20'h5A3C9);
                    end
                end else if (k % 3 != 2) begin
                    if ((b == (k * 5) % (FB - 2) || b == (k * 5) % (FB - 2) + 1) && ph == 1) begin
                        tx_load = 1'b1;    // second attempt is ignored (R6)
                        if (k == 0)      tx_word = '1;
                        else if (k == 1) tx_word = OUT_W'(20'hAAAA5);
                        else             tx_word = OUT_W'((32'h9E3779B1 * k) >> 5) ^ OUT_W'(b);
                    end
                end
            end

            // Advance model over the coming posedge
            rdy = run && !pend_v;
            exp_done = bnd && run;
            if (ph == HALF && b < IN_W) begin
                sh0 = {sh0[IN_W-2:0], link_sdi[0]};
                sh1 = {sh1[IN_W-2:0], link_sdi[1]};
            end
            if (bnd) begin
                if (run) begin
                    exp_rx0 = sh0;
                    exp_rx1 = sh1;
                end
                cur_w  = pend_v ? pend_w : '0;
                pend_v = 1'b0;
            end
            if (tx_load && rdy) begin
                pend_v = 1'b1;
                pend_w = tx_word;
            end
            @(negedge clk);
        end
        tx_load = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk("R1 re-reset link_rst_n", 64'(link_rst_n), 64'd0);
        chk("R5 re-reset tx_ready", 64'(tx_ready), 64'd0);
        chk("R2 re-reset link_sdo", 64'(link_sdo), 64'd0);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (TOTAL + 2000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog all actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule